// File: doc/BRIEF.md
# Quadrature Pulse Converter

This block sits between an incremental encoder and a plain up/down counter. It receives the encoder's two phase-shifted channels, A and B, on one system clock. Each channel is resynchronised and then filtered, so that a level is accepted only after it has held steady for a programmable number of cycles. The decoder turns accepted edges into count events at one, two or four events per quadrature cycle.

Each count event fires a one-shot pulse whose length comes from a pulse-width input given in clock cycles. The pulse is presented in two forms at the same time. The first form is a pair of active-low lines, one for up and one for down. The second form is a single active-low count clock with a direction level beside it. While a pulse is running, and for one recovery cycle after it, the decoder is locked out. When the lockout ends, the decoder compares the current filtered levels with the last state it accepted, so encoder dither that comes and goes during a pulse produces nothing.

Top module: `qenc_pulse_conv`

## Requirements
- R1: After reset, `up_n`, `dn_n` and `cnt_clk` are high, `cnt_dir` is high, and the accepted input state is A=0, B=0.
- R2: Each input passes a two-flop synchroniser. A new level on A or B is accepted only after it has been seen for `FILT_CYCLES` consecutive cycles. A change that lasts fewer cycles produces no pulse.
- R3: With `res_sel` = 2, every accepted single-channel edge gives one pulse. The forward order of {A,B} is 00, 10, 11, 01 (A leads B) and counts up. The reverse order counts down.
- R4: With `res_sel` = 1, only A edges count, giving two pulses per cycle. An edge counts up when A differs from B after the edge, and down otherwise.
- R5: With `res_sel` = 0, only rising edges of A count, giving one pulse per cycle. The event counts up when B is low at that edge and down when B is high.
- R6: `res_sel` = 3 behaves exactly like `res_sel` = 2.
- R7: An up event pulses `up_n` low and a down event pulses `dn_n` low. The two are never low together.
- R8: Each pulse stays low for max(`pw_cycles`, 1) cycles. The width is taken from `pw_cycles` in the cycle the pulse is launched.
- R9: `cnt_clk` is low exactly when `up_n` or `dn_n` is low. `cnt_dir` is 1 for up and 0 for down. `cnt_dir` changes only when a pulse starts, so it is stable through the rising edge of `cnt_clk`.
- R10: From the launch of a pulse until one cycle after `cnt_clk` returns high, no new event is decoded. After that, at most one event is raised, from the difference between the filtered levels and the last accepted state. If the levels have returned to that state, no event is raised.
- R11: When both A and B differ from the accepted state at evaluation, no pulse is issued and the accepted state takes the new levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Encoder channel A, asynchronous |
| enc_b | input | 1 | Encoder channel B, asynchronous |
| res_sel | input | 2 | Resolution: 0 = x1, 1 = x2, 2 or 3 = x4 |
| pw_cycles | input | PW_BITS | Output pulse width in clock cycles (0 acts as 1) |
| up_n | output | 1 | Active-low up pulse |
| dn_n | output | 1 | Active-low down pulse |
| cnt_clk | output | 1 | Active-low combined count clock; the counter counts on its rising edge |
| cnt_dir | output | 1 | Count direction, 1 = up, 0 = down |

## Verification
Two functions can meet in the same cycle: the release of the lockout, when the pulse machine leaves its recovery state, and a filtered edge that qualified while the lockout was active. The bench provokes this in three ways. It makes an input change qualify in the middle of a long pulse. It dithers A forward and back during a pulse. It moves both channels while locked, so that the comparison at release sees an illegal two-bit jump. A behavioural model in the bench predicts every output on every clock. Separate pulse counts, widths and direction tallies confirm that release raises exactly one event, or none.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

    // Resolution select codes; code 3 is folded onto x4
    typedef enum logic [1:0] {
        RES_X1     = 2'd0,
        RES_X2     = 2'd1,
        RES_X4     = 2'd2,
        RES_X4_ALT = 2'd3
    } res_e;

    // One-shot pulse machine
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_GAP   = 2'd2
    } pulse_st_e;

    // Input qualification machine, one per channel
    typedef enum logic {
        F_STEADY  = 1'b0,
        F_QUALIFY = 1'b1
    } filt_st_e;

    typedef struct packed {
        logic valid;
        logic up;
    } qevt_t;

endpackage

// File: rtl/qpc_in_filter.sv
module qpc_in_filter
    import qpc_pkg::*;
#(
    parameter int FILT_CYCLES = 13,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(FILT_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   smp;
    filt_st_e               st_q, st_d;
    logic [CW-1:0]          cnt_q, cnt_d;
    logic                   lvl_q, lvl_d;

    // Synchroniser chain
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
        end
    end

    assign smp = sync_q[SYNC_STAGES-1];

    // Next state and counter
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        lvl_d = lvl_q;
        unique case (st_q)
            F_STEADY: begin
                if (smp != lvl_q) begin
                    if (LAST == '0) begin
                        lvl_d = smp;
                    end else begin
                        st_d  = F_QUALIFY;
                        cnt_d = ONE;
                    end
                end
            end
            F_QUALIFY: begin
                if (smp == lvl_q) begin
                    st_d  = F_STEADY;
                    cnt_d = '0;
                end else if (cnt_q == LAST) begin
                    st_d  = F_STEADY;
                    cnt_d = '0;
                    lvl_d = smp;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= F_STEADY;
            cnt_q <= '0;
            lvl_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            lvl_q <= lvl_d;
        end
    end

    assign clean = lvl_q;

endmodule

// File: rtl/qpc_decoder.sv
module qpc_decoder
    import qpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lock,
    input  logic [1:0] res_sel,
    input  logic       a_f,
    input  logic       b_f,
    output qevt_t      evt
);
    logic acc_a_q, acc_b_q;
    logic chg_a, chg_b, single;
    res_e mode;

    assign chg_a  = a_f ^ acc_a_q;
    assign chg_b  = b_f ^ acc_b_q;
    assign single = chg_a ^ chg_b;
    assign mode   = res_e'(res_sel);

    always_comb begin
        evt = '0;
        if (!lock && single) begin
            unique case (mode)
                RES_X1: begin
                    evt.valid = chg_a & a_f;
                    evt.up    = ~b_f;
                end
                RES_X2: begin
                    evt.valid = chg_a;
                    evt.up    = a_f ^ b_f;
                end
                RES_X4, RES_X4_ALT: begin
                    evt.valid = 1'b1;
                    evt.up    = chg_a ? (a_f ^ b_f) : ~(a_f ^ b_f);
                end
            endcase
        end
    end

    // Last accepted state; refreshed on any difference while unlocked
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_a_q <= 1'b0;
            acc_b_q <= 1'b0;
        end else if (!lock && (chg_a || chg_b)) begin
            acc_a_q <= a_f;
            acc_b_q <= b_f;
        end
    end

endmodule

// File: rtl/qpc_pulse_fsm.sv
module qpc_pulse_fsm
    import qpc_pkg::*;
#(
    parameter int PW_BITS = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  qevt_t              evt,
    input  logic [PW_BITS-1:0] pw_cycles,
    output logic               busy,
    output logic               up_n,
    output logic               dn_n,
    output logic               cnt_clk,
    output logic               cnt_dir
);
    localparam logic [PW_BITS-1:0] ONE = PW_BITS'(1);

    pulse_st_e          st_q, st_d;
    logic               dir_q;
    logic [PW_BITS-1:0] wid_q;
    logic [PW_BITS-1:0] pcnt_q;
    logic [PW_BITS-1:0] pw_eff;
    logic               done;

    assign pw_eff = (pw_cycles == '0) ? ONE : pw_cycles;
    assign done   = (pcnt_q >= wid_q);

    // Transitions: IDLE->PULSE on event, PULSE->GAP at width, GAP->IDLE
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (evt.valid) st_d = ST_PULSE;
            ST_PULSE: if (done)      st_d = ST_GAP;
            ST_GAP:                  st_d = ST_IDLE;
            default:                 st_d = ST_IDLE;
        endcase
    end

    // State register and pulse datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            dir_q  <= 1'b1;
            wid_q  <= ONE;
            pcnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && evt.valid) begin
                dir_q  <= evt.up;
                wid_q  <= pw_eff;
                pcnt_q <= ONE;
            end else if (st_q == ST_PULSE && !done) begin
                pcnt_q <= pcnt_q + ONE;
            end
        end
    end

    // Outputs
    always_comb begin
        busy    = (st_q != ST_IDLE);
        up_n    = ~((st_q == ST_PULSE) &  dir_q);
        dn_n    = ~((st_q == ST_PULSE) & ~dir_q);
        cnt_clk = ~(st_q == ST_PULSE);
        cnt_dir = dir_q;
    end

endmodule

// File: rtl/qenc_pulse_conv.sv
module qenc_pulse_conv
    import qpc_pkg::*;
#(
    parameter int FILT_CYCLES = 13,
    parameter int SYNC_STAGES = 2,
    parameter int PW_BITS     = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enc_a,
    input  logic               enc_b,
    input  logic [1:0]         res_sel,
    input  logic [PW_BITS-1:0] pw_cycles,
    output logic               up_n,
    output logic               dn_n,
    output logic               cnt_clk,
    output logic               cnt_dir
);
    localparam int NCH = 2;

    logic [NCH-1:0] raw_ch;
    logic [NCH-1:0] clean_ch;
    logic           busy;
    qevt_t          evt;

    assign raw_ch = {enc_b, enc_a};

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        qpc_in_filter #(
            .FILT_CYCLES(FILT_CYCLES),
            .SYNC_STAGES(SYNC_STAGES)
        ) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (raw_ch[g]),
            .clean(clean_ch[g])
        );
    end

    qpc_decoder u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .lock   (busy),
        .res_sel(res_sel),
        .a_f    (clean_ch[0]),
        .b_f    (clean_ch[1]),
        .evt    (evt)
    );

    qpc_pulse_fsm #(
        .PW_BITS(PW_BITS)
    ) u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .pw_cycles(pw_cycles),
        .busy     (busy),
        .up_n     (up_n),
        .dn_n     (dn_n),
        .cnt_clk  (cnt_clk),
        .cnt_dir  (cnt_dir)
    );

endmodule

// File: rtl/qpc_checker.sv
module qpc_checker #(
    parameter int PW_BITS = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [PW_BITS-1:0] pw_cycles,
    input logic               up_n,
    input logic               dn_n,
    input logic               cnt_clk,
    input logic               cnt_dir
);
    localparam logic [PW_BITS-1:0] ONE = PW_BITS'(1);

    logic [PW_BITS-1:0] prev_pw, exp_w, low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_pw <= ONE;
            exp_w   <= ONE;
            low_run <= '0;
        end else begin
            prev_pw <= pw_cycles;
            if (!cnt_clk) begin
                if (low_run == '0 || exp_w == '0) begin
                    low_run <= ONE;
                end else begin
                    low_run <= low_run + ONE;
                end
            end else begin
                low_run <= '0;
            end
            if (!cnt_clk && low_run == '0) begin
                exp_w <= (prev_pw == '0) ? ONE : prev_pw;
            end
        end
    end

    // R7: the two pulse lines are never active together
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!up_n && !dn_n));

    // R8: low time of each pulse equals the width latched at launch
    a_r8_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnt_clk) |-> (low_run == exp_w));

    // R9: combined clock mirrors the separate lines
    a_r9_clk_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clk == (up_n && dn_n));

    // R9: direction moves only when a pulse is launched
    a_r9_dir_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(cnt_clk) |-> $stable(cnt_dir));

    // R10: a recovery cycle follows every pulse
    a_r10_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnt_clk) |=> cnt_clk);

endmodule

bind qenc_pulse_conv qpc_checker #(.PW_BITS(PW_BITS)) u_qpc_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pw_cycles(pw_cycles),
    .up_n     (up_n),
    .dn_n     (dn_n),
    .cnt_clk  (cnt_clk),
    .cnt_dir  (cnt_dir)
);

// File: tb/qenc_pulse_conv_bench.sv
`timescale 1ns/1ps
module qenc_pulse_conv_bench;
    localparam int FILT = 13;
    localparam int PWB  = 16;
    localparam int HOLD = 60;
    localparam int LONG = 300;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           a = 1'b0, b = 1'b0;
    logic [1:0]     res = 2'd2;
    logic [PWB-1:0] pw = 16'd20;
    wire            up_n, dn_n, cnt_clk, cnt_dir;

    int checks = 0, errors = 0, cyc = 0;
    bit started = 0, done_flag = 0;

    always #2 clk = ~clk;

    qenc_pulse_conv #(.FILT_CYCLES(FILT), .SYNC_STAGES(2), .PW_BITS(PWB)) u_qenc_pulse_conv (
        .clk(clk), .rst_n(rst_n), .enc_a(a), .enc_b(b), .res_sel(res),
        .pw_cycles(pw), .up_n(up_n), .dn_n(dn_n), .cnt_clk(cnt_clk), .cnt_dir(cnt_dir));

    // Behavioural reference model
    int s1[2], s2[2], fl[2], fc[2], acc[2];
    int mst = 0, mwid = 1, mpc = 0;
    bit mdir = 1, ev, evup, lock;
    bit ca, cb;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                s1[i] = 0; s2[i] = 0; fl[i] = 0; fc[i] = 0; acc[i] = 0;
            end
            mst = 0; mdir = 1; mwid = 1; mpc = 0;
        end else begin
            lock = (mst != 0);
            ca = (fl[0] != acc[0]);
            cb = (fl[1] != acc[1]);
            ev = 0; evup = 0;
            if (!lock && (ca != cb)) begin
                if (res == 2'd0) begin
                    if (ca && fl[0] == 1) begin ev = 1; evup = (fl[1] == 0); end
                end else if (res == 2'd1) begin
                    if (ca) begin ev = 1; evup = (fl[0] != fl[1]); end
                end else begin
                    ev = 1;
                    evup = ca ? (fl[0] != fl[1]) : (fl[0] == fl[1]);
                end
            end
            if (!lock && (ca || cb)) begin acc[0] = fl[0]; acc[1] = fl[1]; end
            if (mst == 0) begin
                if (ev) begin mst = 1; mdir = evup; mwid = (pw == 0) ? 1 : int'(pw); mpc = 1; end
            end else if (mst == 1) begin
                if (mpc >= mwid) mst = 2; else mpc++;
            end else begin
                mst = 0;
            end
            for (int i = 0; i < 2; i++) begin
                if (s2[i] != fl[i]) begin
                    fc[i]++;
                    if (fc[i] >= FILT) begin fl[i] = s2[i]; fc[i] = 0; end
                end else begin
                    fc[i] = 0;
                end
                s2[i] = s1[i];
            end
            s1[0] = int'(a); s1[1] = int'(b);
        end
    end

    // Observation counters
    int n_up = 0, n_dn = 0, n_scu = 0, n_scd = 0, run = 0, last_w = 0;
    bit p_up = 1, p_dn = 1, p_clk = 1;

    always @(negedge clk) begin
        if (rst_n && started && !done_flag) begin
            bit e_up, e_dn, e_clk;
            e_up  = !(mst == 1 && mdir);
            e_dn  = !(mst == 1 && !mdir);
            e_clk = !(mst == 1);
            checks++;
            if (up_n !== e_up || dn_n !== e_dn || cnt_clk !== e_clk || cnt_dir !== mdir) begin
                errors++;
                $display("FAIL R7 R9 model compare t=%0t act up_n=%b dn_n=%b clk=%b dir=%b exp %b %b %b %b",
                         $time, up_n, dn_n, cnt_clk, cnt_dir, e_up, e_dn, e_clk, mdir);
            end
            if (p_up && !up_n) n_up++;
            if (p_dn && !dn_n) n_dn++;
            if (!p_clk && cnt_clk) begin
                last_w = run; run = 0;
                if (cnt_dir) n_scu++; else n_scd++;
            end
            if (!cnt_clk) run++;
            p_up = up_n; p_dn = dn_n; p_clk = cnt_clk;
        end
    end

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clr();
        n_up = 0; n_dn = 0; n_scu = 0; n_scd = 0;
    endtask

    task automatic expect_counts(string tag, int eu, int ed);
        check(n_up == eu, {tag, " up pulses"}, n_up, eu);
        check(n_dn == ed, {tag, " down pulses"}, n_dn, ed);
        check(n_scu == eu, {tag, " R9 clk rises with dir=1"}, n_scu, eu);
        check(n_scd == ed, {tag, " R9 clk rises with dir=0"}, n_scd, ed);
    endtask

    task automatic drive(bit na, bit nb, int n);
        @(posedge clk); #1;
        a = na; b = nb;
        repeat (n) @(posedge clk);
    endtask

    task automatic cycles(bit fwd, int n);
        for (int k = 0; k < n; k++) begin
            if (fwd) begin
                drive(1, 0, HOLD); drive(1, 1, HOLD); drive(0, 1, HOLD); drive(0, 0, HOLD);
            end else begin
                drive(0, 1, HOLD); drive(1, 1, HOLD); drive(1, 0, HOLD); drive(0, 0, HOLD);
            end
        end
    endtask

    task automatic finish_run();
        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done_flag) begin
            errors++;
            $display("FAIL watchdog expired actual %0d expected below 150000", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1;
        started = 1;
        @(negedge clk);
        // R1 reset state
        check(up_n == 1 && dn_n == 1, "R1 pulse lines idle high", {up_n, dn_n}, 3);
        check(cnt_clk == 1 && cnt_dir == 1, "R1 clk and dir high", {cnt_clk, cnt_dir}, 3);
        repeat (HOLD) @(posedge clk);
        check(n_up == 0 && n_dn == 0, "R1 no pulse from reset state 00", n_up + n_dn, 0);

        // R3 x4
        clr(); cycles(1, 2); expect_counts("R3 x4 forward", 8, 0);
        clr(); cycles(0, 2); expect_counts("R3 x4 reverse", 0, 8);
        // R4 x2
        res = 2'd1;
        clr(); cycles(1, 2); expect_counts("R4 x2 forward", 4, 0);
        clr(); cycles(0, 2); expect_counts("R4 x2 reverse", 0, 4);
        // R5 x1
        res = 2'd0;
        clr(); cycles(1, 2); expect_counts("R5 x1 forward", 2, 0);
        clr(); cycles(0, 2); expect_counts("R5 x1 reverse", 0, 2);
        // R6 code 3
        res = 2'd3;
        clr(); cycles(1, 1); expect_counts("R6 code3 forward", 4, 0);
        clr(); cycles(0, 1); expect_counts("R6 code3 reverse", 0, 4);

        // R8 widths
        res = 2'd2;
        pw = 16'd7; drive(1, 0, HOLD);
        check(last_w == 7, "R8 width 7", last_w, 7);
        pw = 16'd0; drive(1, 1, HOLD);
        check(last_w == 1, "R8 width zero acts as 1", last_w, 1);
        pw = 16'd45; drive(0, 1, 2 * HOLD);
        check(last_w == 45, "R8 width 45", last_w, 45);
        pw = 16'd20; drive(0, 0, HOLD);

        // R2 glitch filter
        clr();
        @(posedge clk); #1 a = 1;
        repeat (FILT - 1) @(posedge clk); #1 a = 0;
        repeat (HOLD) @(posedge clk);
        expect_counts("R2 glitch one cycle short", 0, 0);
        clr();
        @(posedge clk); #1 a = 1;
        repeat (FILT) @(posedge clk); #1 a = 0;
        repeat (2 * HOLD) @(posedge clk);
        expect_counts("R2 R10 change of full length then return", 1, 1);

        // R10 dither during a long pulse
        pw = 16'd200; clr();
        drive(1, 0, 30); drive(0, 0, 30); drive(1, 0, LONG);
        expect_counts("R10 dither rejected", 1, 0);

        // R11 illegal jump formed during lockout
        clr();
        drive(1, 1, 30); drive(0, 1, 30); drive(0, 0, LONG);
        expect_counts("R11 two-bit jump at release ignored", 1, 0);
        drive(1, 0, LONG);
        expect_counts("R11 accepted state moved to 00", 2, 0);

        // R11 simultaneous jump while unlocked
        pw = 16'd20;
        drive(0, 0, HOLD); clr();
        drive(1, 1, HOLD);
        expect_counts("R11 direct 00 to 11", 0, 0);
        drive(0, 1, HOLD);
        expect_counts("R11 accepted state moved to 11", 1, 0);
        drive(0, 0, HOLD);

        finish_run();
    end

endmodule